// File: doc/BRIEF.md
# EEPROM Image Loader with Checksum Validation

This block sits between on-chip consumers of configuration data and a serial EEPROM word-access engine. It copies the full 64-word image into a local shadow store. While it does so it keeps a 16-bit running sum that wraps on overflow. The image is accepted only if that sum lands on a fixed target and the signature field of word 0 carries the valid pattern. Consumers then fetch words by index from the shadow copy, so the slow serial device is not touched again while the copy stays trusted.

The block accepts four commands, each a one-cycle pulse, and only while it is idle: a forced load, an indexed lookup, a single word write and a checksum rewrite. A lookup is served straight from the shadow store when the cached signature is good. Otherwise it first runs a full load and then answers. Any write to the device clears the cached signature, so the next lookup refetches the image. The checksum rewrite reads words 0 to 62 from the device and writes the balancing value into word 63.

Toward the word-access engine the block holds a request, with its address, direction and write data, steady until a one-cycle grant arrives. On a read, that grant also carries the returned word.

The controller has eight states:

| State | Role | Leaves to |
|---|---|---|
| IDLE | Accepts commands. | S_WR on a write; S_UP_RD on an update; S_LD_RD on a load or a lookup miss; S_LK_OUT on a lookup hit or an out-of-range index. |
| S_LD_RD | Reads the image word by word. | S_LD_CHK after the grant for word 63. |
| S_LD_CHK | Judges the sum and the signature. | S_LK_OUT if a lookup is pending, otherwise S_FIN. |
| S_LK_OUT | Presents the lookup result. | IDLE. |
| S_UP_RD | Sums words 0 to 62. | S_UP_WR after the grant for word 62. |
| S_UP_WR | Writes the balancing word. | S_FIN on its grant. |
| S_WR | Performs a single word write. | S_FIN on its grant. |
| S_FIN | Signals completion. | IDLE. |

Top module: `eeprom_image_loader`

## Requirements
- R1: After reset, `status` is 2'b00 (empty), `busy` is 0, `done` is 0 and `ee_req` is 0.
- R2: A load issues exactly 64 read requests (`ee_we`=0) to addresses 0, 1, ..., 63 in ascending order, and `status` reads 2'b01 (loading) from the cycle after the command is accepted.
- R3: Words are summed modulo 2^16. A load whose wrapped sum equals 16'hBABA and whose word 0 has bits [15:14] equal to 2'b01 ends with `status` 2'b10 (valid).
- R4: A load whose wrapped sum differs from 16'hBABA ends with `status` 2'b11 (invalid) and clears the cached signature, so that the next in-range lookup performs a full reload.
- R5: A load with a correct sum but with word 0 bits [15:14] other than 2'b01 ends with `status` 2'b11.
- R6: A lookup with an index below 64 while the cached signature is valid returns the shadow word, with `lk_valid` and `done` high for one cycle and no EEPROM request.
- R7: A lookup with an index below 64 while the cached signature is not valid first performs a full load and then returns the word, or zero if the load fails.
- R8: A lookup with an index of 64 or more returns zero and makes no EEPROM request.
- R9: A lookup answered after a failed load (sum or signature) returns zero.
- R10: The checksum update reads words 0 to 62 in order, then writes (16'hBABA minus their wrapped sum) to address 63.
- R11: The grant of any EEPROM write, whether a plain write or a checksum update, sets `status` to 2'b00 and invalidates the cached signature.
- R12: Commands are sampled only while `busy` is 0. If several arrive in the same cycle, the priority is write, then update, then load, then lookup, and the others are dropped.
- R13: While `ee_req` is high and `ee_gnt` is low, `ee_req`, `ee_addr`, `ee_we` and `ee_wdata` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_load | input | 1 | Pulse: force a full image load |
| cmd_lookup | input | 1 | Pulse: look up a word by index |
| lk_index | input | 7 | Index of the word to look up |
| cmd_update | input | 1 | Pulse: recompute and write the checksum word |
| cmd_write | input | 1 | Pulse: write one EEPROM word |
| wr_addr | input | 6 | Address for the word write |
| wr_data | input | 16 | Data for the word write |
| ee_req | output | 1 | Request to the EEPROM word engine |
| ee_we | output | 1 | 1 = write request, 0 = read request |
| ee_addr | output | 6 | Word address of the request |
| ee_wdata | output | 16 | Data of a write request |
| ee_gnt | input | 1 | One-cycle completion of the current request |
| ee_rdata | input | 16 | Read word, valid with `ee_gnt` |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse when a command ends |
| status | output | 2 | 00 empty, 01 loading, 10 valid, 11 invalid |
| lk_valid | output | 1 | Lookup result is present this cycle |
| lk_data | output | 16 | Lookup result |

## Verification
Two functions can be requested in the same cycle: a word write that invalidates the cache and a lookup that would read it. The bench raises `cmd_write` and `cmd_lookup` on the same edge. It then judges that exactly one write reached the EEPROM model, that no read was issued, that no `lk_valid` pulse appeared before `done`, and that `status` fell to empty. It also pulses `cmd_load` while a load is running and confirms that the read count rises by exactly 64.

// File: rtl/eel_pkg.sv
package eel_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'b00,
        ST_LOADING = 2'b01,
        ST_VALID   = 2'b10,
        ST_INVALID = 2'b11
    } img_status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LD_RD,
        S_LD_CHK,
        S_LK_OUT,
        S_UP_RD,
        S_UP_WR,
        S_WR,
        S_FIN
    } ldr_state_e;

endpackage

// File: rtl/eel_shadow.sv
module eel_shadow #(
    parameter int          AW        = 6,
    parameter int          DW        = 16,
    parameter logic [15:0] SIG_MASK  = 16'hC000,
    parameter logic [15:0] SIG_VALID = 16'h4000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          sig_clr,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          sig_ok
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] word_q [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        if (g == 0) begin : g_sig_word
            // word 0 carries the signature; clearing only touches its field
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q[g] <= '0;
                end else if (sig_clr) begin
                    word_q[g] <= word_q[g] & ~DW'(SIG_MASK);
                end else if (wr_en && wr_addr == AW'(g)) begin
                    word_q[g] <= wr_data;
                end
            end
        end else begin : g_plain_word
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q[g] <= '0;
                end else if (wr_en && wr_addr == AW'(g)) begin
                    word_q[g] <= wr_data;
                end
            end
        end
    end

    assign rd_data = word_q[rd_addr];
    assign sig_ok  = (word_q[0] & DW'(SIG_MASK)) == DW'(SIG_VALID);

endmodule

// File: rtl/eel_accum.sv
module eel_accum #(
    parameter int          DW     = 16,
    parameter logic [15:0] TARGET = 16'hBABA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          add_en,
    input  logic [DW-1:0] add_val,
    output logic          match,
    output logic [DW-1:0] balance
);
    logic [DW-1:0] sum_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sum_q <= '0;
        end else if (add_en) begin
            sum_q <= sum_q + add_val;   // wraps modulo 2^DW
        end
    end

    assign match   = (sum_q == DW'(TARGET));
    assign balance = DW'(TARGET) - sum_q;

endmodule

// File: rtl/eel_ctrl.sv
module eel_ctrl
    import eel_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16,
    parameter int IW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_load,
    input  logic          cmd_lookup,
    input  logic [IW-1:0] lk_index,
    input  logic          cmd_update,
    input  logic          cmd_write,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          ee_req,
    output logic          ee_we,
    output logic [AW-1:0] ee_addr,
    output logic [DW-1:0] ee_wdata,
    input  logic          ee_gnt,
    input  logic [DW-1:0] ee_rdata,
    output logic          busy,
    output logic          done,
    output logic [1:0]    status,
    output logic          lk_valid,
    output logic [DW-1:0] lk_data,
    output logic          sh_we,
    output logic [AW-1:0] sh_waddr,
    output logic          sh_sig_clr,
    output logic [AW-1:0] sh_raddr,
    input  logic [DW-1:0] sh_rdata,
    input  logic          sig_ok,
    output logic          acc_clr,
    output logic          acc_add,
    input  logic          sum_match,
    input  logic [DW-1:0] sum_balance
);
    localparam int            WORDS     = 1 << AW;
    localparam logic [AW-1:0] LAST_ADDR = AW'(WORDS - 1);
    localparam logic [AW-1:0] PRE_LAST  = AW'(WORDS - 2);
    localparam logic [IW-1:0] IDX_LIMIT = IW'(WORDS);

    ldr_state_e  state_q, state_d;
    img_status_e status_q;
    logic [AW-1:0] cnt_q;
    logic [IW-1:0] idx_q;
    logic [AW-1:0] wa_q;
    logic [DW-1:0] wd_q;
    logic          lk_pend_q;

    logic idx_oor_in;
    logic idx_oor_q;
    assign idx_oor_in = (lk_index >= IDX_LIMIT);
    assign idx_oor_q  = (idx_q >= IDX_LIMIT);

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_write)       state_d = S_WR;
                else if (cmd_update) state_d = S_UP_RD;
                else if (cmd_load)   state_d = S_LD_RD;
                else if (cmd_lookup) state_d = (idx_oor_in || sig_ok) ? S_LK_OUT : S_LD_RD;
            end
            S_LD_RD:  if (ee_gnt && cnt_q == LAST_ADDR) state_d = S_LD_CHK;
            S_LD_CHK: state_d = lk_pend_q ? S_LK_OUT : S_FIN;
            S_LK_OUT: state_d = S_IDLE;
            S_UP_RD:  if (ee_gnt && cnt_q == PRE_LAST) state_d = S_UP_WR;
            S_UP_WR:  if (ee_gnt) state_d = S_FIN;
            S_WR:     if (ee_gnt) state_d = S_FIN;
            S_FIN:    state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // command latches, word counter and image status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q  <= ST_EMPTY;
            cnt_q     <= '0;
            idx_q     <= '0;
            wa_q      <= '0;
            wd_q      <= '0;
            lk_pend_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    cnt_q <= '0;
                    if (cmd_write) begin
                        wa_q <= wr_addr;
                        wd_q <= wr_data;
                    end else if (cmd_update) begin
                        lk_pend_q <= 1'b0;
                    end else if (cmd_load) begin
                        lk_pend_q <= 1'b0;
                        status_q  <= ST_LOADING;
                    end else if (cmd_lookup) begin
                        idx_q     <= lk_index;
                        lk_pend_q <= 1'b1;
                        if (!(idx_oor_in || sig_ok)) status_q <= ST_LOADING;
                    end
                end
                S_LD_RD, S_UP_RD: begin
                    if (ee_gnt) cnt_q <= cnt_q + 1'b1;
                end
                S_LD_CHK: begin
                    status_q <= (sum_match && sig_ok) ? ST_VALID : ST_INVALID;
                end
                S_UP_WR, S_WR: begin
                    if (ee_gnt) status_q <= ST_EMPTY;
                end
                S_LK_OUT, S_FIN: ;
                default: ;
            endcase
        end
    end

    // outputs decoded from the current state
    always_comb begin
        ee_req     = 1'b0;
        ee_we      = 1'b0;
        ee_addr    = cnt_q;
        ee_wdata   = '0;
        done       = 1'b0;
        lk_valid   = 1'b0;
        lk_data    = '0;
        sh_we      = 1'b0;
        sh_sig_clr = 1'b0;
        acc_add    = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_LD_RD: begin
                ee_req  = 1'b1;
                sh_we   = ee_gnt;
                acc_add = ee_gnt;
            end
            S_LD_CHK: sh_sig_clr = !sum_match;
            S_LK_OUT: begin
                lk_valid = 1'b1;
                done     = 1'b1;
                lk_data  = (!idx_oor_q && sig_ok) ? sh_rdata : '0;
            end
            S_UP_RD: begin
                ee_req  = 1'b1;
                acc_add = ee_gnt;
            end
            S_UP_WR: begin
                ee_req     = 1'b1;
                ee_we      = 1'b1;
                ee_addr    = LAST_ADDR;
                ee_wdata   = sum_balance;
                sh_sig_clr = ee_gnt;
            end
            S_WR: begin
                ee_req     = 1'b1;
                ee_we      = 1'b1;
                ee_addr    = wa_q;
                ee_wdata   = wd_q;
                sh_sig_clr = ee_gnt;
            end
            S_FIN: done = 1'b1;
            default: ;
        endcase
    end

    assign busy     = (state_q != S_IDLE);
    assign status   = status_q;
    assign sh_waddr = cnt_q;
    assign sh_raddr = idx_q[AW-1:0];
    assign acc_clr  = (state_q == S_IDLE);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (ee_req && !ee_gnt) |=> (ee_req && $stable(ee_addr) && $stable(ee_we) && $stable(ee_wdata))); // R13
    AST_LOAD_STEP: assert property (@(posedge clk) disable iff (!rst_n) (state_q == S_LD_RD && ee_gnt && cnt_q != LAST_ADDR) |=> (ee_addr == AW'($past(ee_addr) + 1'b1))); // R2
    AST_FAIL_CLEARS_SIG: assert property (@(posedge clk) disable iff (!rst_n) (state_q == S_LD_CHK && !sum_match) |=> (!sig_ok && status_q == ST_INVALID)); // R4
    AST_WRITE_INVALIDATES: assert property (@(posedge clk) disable iff (!rst_n) (ee_req && ee_we && ee_gnt) |=> (!sig_ok && status_q == ST_EMPTY)); // R11
    AST_NOT_VALID_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (lk_valid && status_q != ST_VALID) |-> (lk_data == '0)); // R9
    AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (lk_valid && idx_oor_q) |-> (lk_data == '0)); // R8

endmodule

// File: rtl/eeprom_image_loader.sv
module eeprom_image_loader #(
    parameter int          AW        = 6,
    parameter int          DW        = 16,
    parameter logic [15:0] SUM_TGT   = 16'hBABA,
    parameter logic [15:0] SIG_MASK  = 16'hC000,
    parameter logic [15:0] SIG_VALID = 16'h4000,
    localparam int         IW        = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_load,
    input  logic          cmd_lookup,
    input  logic [IW-1:0] lk_index,
    input  logic          cmd_update,
    input  logic          cmd_write,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          ee_req,
    output logic          ee_we,
    output logic [AW-1:0] ee_addr,
    output logic [DW-1:0] ee_wdata,
    input  logic          ee_gnt,
    input  logic [DW-1:0] ee_rdata,
    output logic          busy,
    output logic          done,
    output logic [1:0]    status,
    output logic          lk_valid,
    output logic [DW-1:0] lk_data
);
    logic          sh_we, sh_sig_clr, sig_ok;
    logic [AW-1:0] sh_waddr, sh_raddr;
    logic [DW-1:0] sh_rdata;
    logic          acc_clr, acc_add, sum_match;
    logic [DW-1:0] sum_balance;

    eel_ctrl #(.AW(AW), .DW(DW), .IW(IW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_load   (cmd_load),
        .cmd_lookup (cmd_lookup),
        .lk_index   (lk_index),
        .cmd_update (cmd_update),
        .cmd_write  (cmd_write),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .ee_req     (ee_req),
        .ee_we      (ee_we),
        .ee_addr    (ee_addr),
        .ee_wdata   (ee_wdata),
        .ee_gnt     (ee_gnt),
        .ee_rdata   (ee_rdata),
        .busy       (busy),
        .done       (done),
        .status     (status),
        .lk_valid   (lk_valid),
        .lk_data    (lk_data),
        .sh_we      (sh_we),
        .sh_waddr   (sh_waddr),
        .sh_sig_clr (sh_sig_clr),
        .sh_raddr   (sh_raddr),
        .sh_rdata   (sh_rdata),
        .sig_ok     (sig_ok),
        .acc_clr    (acc_clr),
        .acc_add    (acc_add),
        .sum_match  (sum_match),
        .sum_balance(sum_balance)
    );

    eel_shadow #(.AW(AW), .DW(DW), .SIG_MASK(SIG_MASK), .SIG_VALID(SIG_VALID)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sh_we),
        .wr_addr (sh_waddr),
        .wr_data (ee_rdata),
        .sig_clr (sh_sig_clr),
        .rd_addr (sh_raddr),
        .rd_data (sh_rdata),
        .sig_ok  (sig_ok)
    );

    eel_accum #(.DW(DW), .TARGET(SUM_TGT)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (acc_clr),
        .add_en  (acc_add),
        .add_val (ee_rdata),
        .match   (sum_match),
        .balance (sum_balance)
    );

endmodule

// File: tb/eeprom_image_loader_tb.sv
module eeprom_image_loader_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_load = 0, cmd_lookup = 0, cmd_update = 0, cmd_write = 0;
    logic [6:0]  lk_index = '0;
    logic [5:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        ee_req, ee_we, ee_gnt;
    logic [5:0]  ee_addr;
    logic [15:0] ee_wdata, ee_rdata;
    logic        busy, done, lk_valid;
    logic [1:0]  status;
    logic [15:0] lk_data;

    int n_run = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_image_loader dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .cmd_lookup(cmd_lookup),
        .lk_index(lk_index), .cmd_update(cmd_update), .cmd_write(cmd_write),
        .wr_addr(wr_addr), .wr_data(wr_data), .ee_req(ee_req), .ee_we(ee_we),
        .ee_addr(ee_addr), .ee_wdata(ee_wdata), .ee_gnt(ee_gnt), .ee_rdata(ee_rdata),
        .busy(busy), .done(done), .status(status), .lk_valid(lk_valid), .lk_data(lk_data)
    );

    // EEPROM word engine model
    logic [15:0] mem [64];
    int          rd_log [512];
    int          rd_n = 0, wr_n = 0, wait_c = 0, viol = 0;
    logic [5:0]  last_wa = '0;
    logic [15:0] last_wd = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ee_gnt   <= 1'b0;
            ee_rdata <= '0;
            wait_c   <= 0;
        end else begin
            ee_gnt <= 1'b0;
            if (ee_req && !ee_gnt) begin
                if (wait_c >= LAT) begin
                    ee_gnt <= 1'b1;
                    wait_c <= 0;
                    if (ee_we) begin
                        mem[ee_addr] <= ee_wdata;
                        last_wa      <= ee_addr;
                        last_wd      <= ee_wdata;
                        wr_n         <= wr_n + 1;
                    end else begin
                        ee_rdata <= mem[ee_addr];
                        if (rd_n < 512) rd_log[rd_n] <= int'(ee_addr);
                        rd_n <= rd_n + 1;
                    end
                end else begin
                    wait_c <= wait_c + 1;
                end
            end
        end
    end

    // R13 monitor: pending request must hold steady
    logic        pend_p = 1'b0;
    logic [5:0]  addr_p;
    logic        we_p;
    logic [15:0] wd_p;
    int          lk_pulses = 0;
    always @(negedge clk) begin
        if (pend_p && (!ee_req || ee_addr != addr_p || ee_we != we_p || ee_wdata != wd_p))
            viol++;
        pend_p = rst_n && ee_req && !ee_gnt;
        addr_p = ee_addr; we_p = ee_we; wd_p = ee_wdata;
        if (lk_valid) lk_pulses++;
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // fill words 0..62 from a seed, force signature bits, balance word 63
    task automatic build_image(input logic [15:0] base, input logic [1:0] sig);
        logic [15:0] s;
        s = '0;
        for (int i = 0; i < 63; i++) begin
            mem[i] = base + 16'(i * 16'h0123);
            if (i == 0) mem[i] = {sig, mem[i][13:0]};
            s = s + mem[i];
        end
        mem[63] = 16'hBABA - s;
    endtask

    task automatic pulse_and_wait(output logic got_lk, output logic [15:0] got_data);
        @(negedge clk);
        cmd_load = 0; cmd_lookup = 0; cmd_update = 0; cmd_write = 0;
        while (!done) @(negedge clk);
        got_lk   = lk_valid;
        got_data = lk_data;
        @(negedge clk);
    endtask

    task automatic do_load(output logic [1:0] st);
        logic l; logic [15:0] d;
        cmd_load = 1;
        @(negedge clk);
        cmd_load = 0;
        chk("R2 status loading", 32'(status), 32'h1);
        while (!done) @(negedge clk);
        @(negedge clk);
        st = status;
    endtask

    task automatic do_lookup(input logic [6:0] idx, output logic got, output logic [15:0] d);
        lk_index = idx;
        cmd_lookup = 1;
        pulse_and_wait(got, d);
    endtask

    task automatic t_reset;
        chk("R1 status", 32'(status), 32'h0);
        chk("R1 busy", 32'(busy), 32'h0);
        chk("R1 done", 32'(done), 32'h0);
        chk("R1 ee_req", 32'(ee_req), 32'h0);
    endtask

    task automatic t_good_load;
        logic [1:0] st; int r0; int ok;
        build_image(16'hF000, 2'b01);   // large words: raw sum exceeds 16 bits (R3 wrap)
        r0 = rd_n;
        do_load(st);
        chk("R2 read count", 32'(rd_n - r0), 32'd64);
        ok = 1;
        for (int k = 0; k < 64; k++) if (rd_log[r0 + k] != k) ok = 0;
        chk("R2 ascending order", 32'(ok), 32'd1);
        chk("R3 status valid", 32'(st), 32'h2);
    endtask

    task automatic t_hit_and_oor;
        logic g; logic [15:0] d; int r0;
        r0 = rd_n;
        do_lookup(7'd5, g, d);
        chk("R6 lk_valid", 32'(g), 32'h1);
        chk("R6 data", 32'(d), 32'(mem[5]));
        chk("R6 no access", 32'(rd_n - r0), 32'd0);
        do_lookup(7'd63, g, d);
        chk("R6 word63", 32'(d), 32'(mem[63]));
        do_lookup(7'd70, g, d);
        chk("R8 zero", 32'(d), 32'h0);
        chk("R8 no access", 32'(rd_n - r0), 32'd0);
    endtask

    task automatic t_write_then_miss;
        logic g; logic [15:0] d; int r0, w0;
        w0 = wr_n;
        wr_addr = 6'd10; wr_data = 16'h1234; cmd_write = 1;
        pulse_and_wait(g, d);
        chk("R11 write issued", 32'(wr_n - w0), 32'd1);
        chk("R11 status empty", 32'(status), 32'h0);
        chk("R11 written word", 32'(mem[10]), 32'h1234);
        r0 = rd_n;
        do_lookup(7'd10, g, d);   // checksum now broken
        chk("R7 reload on miss", 32'(rd_n - r0), 32'd64);
        chk("R4 status invalid", 32'(status), 32'h3);
        chk("R9 zero after fail", 32'(d), 32'h0);
        r0 = rd_n;
        do_lookup(7'd3, g, d);
        chk("R4 signature cleared forces reload", 32'(rd_n - r0), 32'd64);
        chk("R9 zero again", 32'(d), 32'h0);
    endtask

    task automatic t_update;
        logic g; logic [15:0] d; logic [15:0] s; int r0, w0, ok;
        s = '0;
        for (int i = 0; i < 63; i++) s = s + mem[i];
        r0 = rd_n; w0 = wr_n;
        cmd_update = 1;
        pulse_and_wait(g, d);
        chk("R10 read count", 32'(rd_n - r0), 32'd63);
        ok = 1;
        for (int k = 0; k < 63; k++) if (rd_log[r0 + k] != k) ok = 0;
        chk("R10 read order", 32'(ok), 32'd1);
        chk("R10 write count", 32'(wr_n - w0), 32'd1);
        chk("R10 write addr", 32'(last_wa), 32'd63);
        chk("R10 write value", 32'(last_wd), 32'(16'hBABA - s));
        chk("R11 status after update", 32'(status), 32'h0);
        r0 = rd_n;
        do_lookup(7'd10, g, d);
        chk("R7 reload after update", 32'(rd_n - r0), 32'd64);
        chk("R7 data after reload", 32'(d), 32'h1234);
        chk("R3 valid after repair", 32'(status), 32'h2);
    endtask

    task automatic t_bad_sig;
        logic [1:0] st; logic g; logic [15:0] d;
        build_image(16'h0A0A, 2'b10);
        do_load(st);
        chk("R5 status invalid", 32'(st), 32'h3);
        do_lookup(7'd1, g, d);
        chk("R9 zero with bad signature", 32'(d), 32'h0);
        build_image(16'h0A0A, 2'b01);
        mem[63] = mem[63] + 16'h0001;
        do_load(st);
        chk("R4 off-by-one sum invalid", 32'(st), 32'h3);
    endtask

    task automatic t_collide;
        logic [1:0] st; int r0, w0, p0; logic g; logic [15:0] d;
        build_image(16'h3300, 2'b01);
        do_load(st);
        chk("R3 fresh valid", 32'(st), 32'h2);
        r0 = rd_n; w0 = wr_n; p0 = lk_pulses;
        wr_addr = 6'd20; wr_data = 16'hBEEF;
        cmd_write = 1; cmd_lookup = 1; lk_index = 7'd2;
        pulse_and_wait(g, d);
        chk("R12 write wins", 32'(wr_n - w0), 32'd1);
        chk("R12 lookup dropped", 32'(lk_pulses - p0), 32'd0);
        chk("R12 no read", 32'(rd_n - r0), 32'd0);
        chk("R11 status empty", 32'(status), 32'h0);
        build_image(16'h3300, 2'b01);
        r0 = rd_n;
        cmd_load = 1;
        @(negedge clk);
        cmd_load = 0;
        repeat (5) @(negedge clk);
        cmd_load = 1;               // busy: must be ignored
        @(negedge clk);
        cmd_load = 0;
        while (!done) @(negedge clk);
        repeat (6) @(negedge clk);
        chk("R12 busy command ignored", 32'(rd_n - r0), 32'd64);
        chk("R12 still idle", 32'(busy), 32'h0);
    endtask

    logic finished = 1'b0;

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_good_load();
        t_hit_and_oor();
        t_write_then_miss();
        t_update();
        t_bad_sig();
        t_collide();
        chk("R13 request stability", 32'(viol), 32'd0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule